// File: doc/BRIEF.md
# Critical-Word-First Line Fill Sequencer

This block moves one 64-byte cache line across an 8-byte-wide bus between two cache levels. It does not start at byte zero. The first beat is the 8-byte chunk that holds the word the requester asked for. Later beats step through higher chunk addresses and wrap from the top chunk to chunk 0, until all eight chunks have arrived. For each beat it gives the line buffer a write strobe, a chunk index and the data. It also keeps a bitmap of the chunks received so far.

A second reader of the same line can ask for any byte offset. It is granted in the same cycle when that chunk is already in the buffer or is being written in that cycle. Otherwise it must wait. A level flag goes high once the demanded chunk has landed, so the consumer can go ahead before the rest of the line arrives. A one-cycle done strobe marks the last beat. No new fill is accepted until that strobe has been issued. The source supplies beats at its own pace: a cycle with `src_valid` low is a stall.

Top module: `cwf_fill_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `wr_en`, `fill_done`, `crit_ready` and `rd_grant` are 0.
- R2: The first beat written after an accepted request carries chunk index `req_offset[5:3]`. Offset bits [2:0] have no effect on this index, so offset 7 starts at chunk 0.
- R3: Each later beat index is the previous index plus one, modulo 8. For example, offset 44 gives chunks 5,6,7,0,1,2,3,4.
- R4: `wr_en` equals `src_valid` while a fill is in progress and is 0 otherwise. A stalled cycle writes nothing and does not advance the sequence. Exactly 8 beats are written per fill.
- R5: `fill_done` is high for exactly one cycle, the cycle of the eighth beat write.
- R6: `req_ready` is 0 from the cycle after acceptance up to and including the `fill_done` cycle, and 1 in the cycle after it. A request presented while busy is ignored and does not change the beat order.
- R7: `crit_ready` becomes 1 on the clock edge that writes the first beat. It stays 1 until the next request is accepted, and it is 0 from that acceptance until the first beat of the new fill.
- R8: `rd_grant` equals `rd_valid` AND (the chunk `rd_offset[5:3]` has been written in the current fill, OR it is being written in this cycle).
- R9: `wr_data` equals `src_data` in every write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fill request |
| req_offset | input | 6 | Byte offset of the demanded word in the line |
| req_ready | output | 1 | High when a request can be accepted |
| src_valid | input | 1 | Source presents a beat |
| src_data | input | 64 | Beat data from the source |
| wr_en | output | 1 | Line buffer write strobe |
| wr_idx | output | 3 | Chunk index written |
| wr_data | output | 64 | Data to write |
| crit_ready | output | 1 | Demanded chunk is in the buffer |
| fill_done | output | 1 | One-cycle strobe on the last beat |
| rd_valid | input | 1 | Consumer access request |
| rd_offset | input | 6 | Byte offset of the consumer access |
| rd_grant | output | 1 | Consumer access can be served now |

## Verification
The main ordering is driven with directed start offsets:
- Offset 0 exercises the no-wrap case.
- Offsets 24 and 44 give a mid-line wrap.
- Offset 60 wraps right after the first beat.
- Offset 7 shows that the low offset bits do not affect the start chunk.

Random fills with random 4-byte-aligned offsets and random source stalls separate a sequencer that advances on stalls from one that advances only on written beats. Consumer probes at random offsets in every cycle, and stray requests during a fill, test the bitmap grant, including the case where the chunk is being written in the same cycle. They also test that the start chunk stays latched while busy.

// File: rtl/cwf_fill_seq.sv
module cwf_fill_seq #(
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BYTES = 8,
  localparam int BEATS  = LINE_BYTES / BEAT_BYTES,
  localparam int IDX_W  = $clog2(BEATS),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int SUB_W  = $clog2(BEAT_BYTES),
  localparam int DATA_W = 8 * BEAT_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OFF_W-1:0]  req_offset,
  output logic              req_ready,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              crit_ready,
  output logic              fill_done,
  input  logic              rd_valid,
  input  logic [OFF_W-1:0]  rd_offset,
  output logic              rd_grant
);

  logic             busy;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] cnt;
  logic [BEATS-1:0] have;
  logic             accept;
  logic             last;
  logic [IDX_W-1:0] rd_idx;

  assign req_ready = ~busy;
  assign accept    = req_valid & ~busy;
  assign wr_en     = busy & src_valid;
  assign wr_idx    = ptr;
  assign wr_data   = src_data;
  assign last      = (cnt == IDX_W'(BEATS - 1));
  assign fill_done = wr_en & last;
  assign rd_idx    = rd_offset[OFF_W-1:SUB_W];
  assign rd_grant  = rd_valid & (have[rd_idx] | (wr_en & (ptr == rd_idx)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      ptr        <= '0;
      cnt        <= '0;
      have       <= '0;
      crit_ready <= 1'b0;
    end else if (accept) begin
      busy       <= 1'b1;
      ptr        <= req_offset[OFF_W-1:SUB_W];
      cnt        <= '0;
      have       <= '0;
      crit_ready <= 1'b0;
    end else if (wr_en) begin
      ptr        <= ptr + IDX_W'(1);
      cnt        <= cnt + IDX_W'(1);
      have[ptr]  <= 1'b1;
      crit_ready <= 1'b1;
      if (last) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/cwf_fill_seq_chk.sv
module cwf_fill_seq_chk #(
  parameter int IDX_W = 3,
  parameter int OFF_W = 6,
  parameter int SUB_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [OFF_W-1:0] req_offset,
  input logic             req_ready,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             crit_ready,
  input logic             fill_done,
  input logic             rd_valid,
  input logic             rd_grant
);
  localparam int BEATS = 1 << IDX_W;

  logic [IDX_W-1:0] exp_q;
  logic [IDX_W:0]   nwr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      nwr   <= '0;
    end else if (req_valid && req_ready) begin
      exp_q <= req_offset[OFF_W-1:SUB_W];
      nwr   <= '0;
    end else if (wr_en) begin
      exp_q <= wr_idx + IDX_W'(1);
      nwr   <= nwr + (IDX_W+1)'(1);
    end
  end

  // R2 start chunk and R3 wrapping increment
  assert_beat_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx == exp_q);
  assert_beat_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> nwr < (IDX_W+1)'(BEATS));
  assert_done_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> (wr_en && nwr == (IDX_W+1)'(BEATS - 1)));
  assert_busy_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !req_ready);
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> req_ready);
  assert_crit_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crit_ready) |-> $past(wr_en));
  assert_grant_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |-> rd_valid);
endmodule

bind cwf_fill_seq cwf_fill_seq_chk #(.IDX_W(IDX_W), .OFF_W(OFF_W), .SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
  .req_ready(req_ready), .wr_en(wr_en), .wr_idx(wr_idx), .crit_ready(crit_ready),
  .fill_done(fill_done), .rd_valid(rd_valid), .rd_grant(rd_grant)
);

// File: tb/cwf_fill_seq_test.sv
module cwf_fill_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_offset = '0;
  logic        req_ready;
  logic        src_valid = 1'b0;
  logic [63:0] src_data = '0;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [63:0] wr_data;
  logic        crit_ready;
  logic        fill_done;
  logic        rd_valid = 1'b0;
  logic [5:0]  rd_offset = '0;
  logic        rd_grant;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] have_m;

  always #2 clk = ~clk;

  cwf_fill_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_ready(req_ready), .src_valid(src_valid), .src_data(src_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .crit_ready(crit_ready),
    .fill_done(fill_done), .rd_valid(rd_valid), .rd_offset(rd_offset), .rd_grant(rd_grant)
  );

  function automatic int exp_idx(input int off, input int n);
    return ((off >> 3) + n) % 8;
  endfunction

  function automatic bit exp_grant(input bit v, input int q, input logic [7:0] m,
                                   input bit w, input int wi);
    return v && (m[q] || (w && wi == q));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fill(input int off, input int stall_pct, input bit poke);
    @(negedge clk);
    req_valid = 1'b1; req_offset = 6'(off);
    #1 chk(req_ready == 1'b1, "R6 ready before accept", req_ready, 1);
    @(posedge clk);
    have_m = '0;
    for (int n = 0; n < 8; ) begin
      bit sv;
      int q;
      @(negedge clk);
      sv = ($urandom_range(99) >= stall_pct);
      src_valid = sv;
      src_data = {$urandom, $urandom};
      rd_valid = $urandom_range(1);
      q = $urandom_range(15);
      rd_offset = 6'(q * 4);
      req_valid = poke && ($urandom_range(3) == 0);
      req_offset = 6'($urandom_range(63));
      #1;
      chk(wr_en == sv, "R4 write follows src_valid", wr_en, sv);
      chk(req_ready == 1'b0, "R6 busy blocks request", req_ready, 0);
      chk(crit_ready == (n > 0), "R7 critical flag", crit_ready, n > 0);
      chk(rd_grant == exp_grant(rd_valid, q / 2, have_m, sv, exp_idx(off, n)),
          "R8 consumer grant", rd_grant, exp_grant(rd_valid, q / 2, have_m, sv, exp_idx(off, n)));
      if (sv) begin
        chk(int'(wr_idx) == exp_idx(off, n), n == 0 ? "R2 first chunk" : "R3 wrap order",
            wr_idx, exp_idx(off, n));
        chk(wr_data == src_data, "R9 data pass", wr_data, src_data);
        chk(fill_done == (n == 7), "R5 done on last beat", fill_done, n == 7);
      end else begin
        chk(fill_done == 1'b0, "R5 no done on stall", fill_done, 0);
      end
      @(posedge clk);
      if (sv) begin
        have_m[exp_idx(off, n)] = 1'b1;
        n++;
      end
    end
    @(negedge clk);
    src_valid = 1'b0; req_valid = 1'b0; rd_valid = 1'b0;
    #1;
    chk(req_ready == 1'b1, "R6 ready after done", req_ready, 1);
    chk(wr_en == 1'b0 && fill_done == 1'b0, "R4 idle no write", {wr_en, fill_done}, 0);
    chk(crit_ready == 1'b1, "R7 flag held", crit_ready, 1);
    src_valid = 1'b1;
    #1 chk(wr_en == 1'b0, "R4 source ignored while idle", wr_en, 0);
    src_valid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && wr_en == 1'b0 && fill_done == 1'b0 && crit_ready == 1'b0,
        "R1 reset outputs", {req_ready, wr_en, fill_done, crit_ready}, 4'b1000);
    rd_valid = 1'b1; rd_offset = 6'd0;
    #1 chk(rd_grant == 1'b0, "R1 no grant after reset", rd_grant, 0);
    rd_valid = 1'b0;
    rst_n = 1'b1;
    do_fill(24, 0, 0);
    do_fill(44, 0, 0);
    do_fill(0, 30, 0);
    do_fill(60, 0, 1);
    do_fill(7, 40, 1);
    for (int i = 0; i < 40; i++) do_fill($urandom_range(15) * 4, $urandom_range(60), 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule